// File: doc/BRIEF.md
# Interrupt Acceptance Gating Unit

This block sits between a processor's instruction sequencer and its interrupt controller. In every clock cycle (one state) it decides whether a pending interrupt may be taken. It raises a one-cycle `accept` pulse only when three conditions hold together. The sequencer must be at a legal acceptance point. No blocking window may be open. The pending request must be eligible under the current interrupt mask.

Blocking windows come from two sources. The first is an instruction that rewrites the mask bit. Such an instruction shuts acceptance for the cycle it ends in and for a fixed number of cycles after it. Acceptance then stays shut until the following instruction has also completed. The new mask value itself reaches the eligibility logic two cycles after the update strobe. The second source is a block-move instruction. A byte-wide move holds off every request, including the non-maskable one, until it finishes. A word-wide move may be interrupted at any break between its transfer cycles. When that happens, `pc_next` tells the stacking logic to save the address of the following instruction.

The unit also conditions the external IRQ pins. In normal clocked operation each pin passes through a two-flop synchronizer. In low-power mode a high pin sets a sticky level without waiting for a clock edge. An interrupt acknowledge clears that sticky level.

Internally, a window state machine has three states:
- `W_OPEN`: no window.
- `W_COUNT`: the post-update counter is running.
- `W_AWAIT`: the counter has expired, but no instruction boundary has been seen since the update.

Its transitions are:
- OPEN→COUNT on an update.
- COUNT→COUNT on a reload by a new update.
- COUNT→OPEN when the counter expires after a boundary has been seen.
- COUNT→AWAIT when the counter expires with no boundary seen.
- AWAIT→OPEN on a boundary.
- AWAIT→COUNT on an update.

An acceptance state machine has two states:
- `A_READY`
- `A_TAKEN`

Its transitions are:
- READY→TAKEN on an accept.
- TAKEN→READY on an acknowledge.

Top module: `irq_accept_gate`

## Requirements
- R1: After reset `accept`, `pc_next` and every bit of `irq_level` are 0, and `mask_now` is 1 (masked).
- R2: A `mask_wr` pulse in cycle t makes `mask_now` equal the `mask_bit` sampled in cycle t from cycle t+2 on; `mask_now` does not change in cycle t+1.
- R3: `accept` stays 0 in the cycle of a `mask_wr` and in the three cycles after it, for the non-maskable request too.
- R4: After a `mask_wr` in cycle t, no accept occurs until an `insn_end` has been seen in some cycle after t. The first accept may occur on that `insn_end` cycle itself, provided the window of R3 has expired.
- R5: A further `mask_wr` while the window of R3 is running restarts the three-cycle window from the new strobe.
- R6: While `bmove_byte` is 1, `accept` stays 0, for the non-maskable request too.
- R7: While `bmove_word` is 1, `accept` may occur only in a cycle with `xfer_gap` = 1, and not on `insn_end`; such an accept drives `pc_next` to 1 in the same cycle.
- R8: Outside block moves, `accept` may occur only in a cycle with `insn_end` = 1, and `pc_next` stays 0.
- R9: `req_nmi` is eligible whatever the mask; `req_mask` is eligible only while `mask_now` is 0; with neither eligible, `accept` stays 0.
- R10: `accept` is a one-cycle pulse. After it, no further accept occurs up to and including the cycle in which `int_ack` is 1. Acceptance resumes in the cycle after that acknowledge.
- R11: With `low_power` at 0, a change on an `irq_pin` bit appears on the matching `irq_level` bit after exactly two rising clock edges.
- R12: With `low_power` at 1, a high `irq_pin` bit sets its `irq_level` bit without any clock edge. The bit then stays 1 after the pin falls, and clears on the first clock edge that sees `int_ack` with the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wr | input | 1 | Strobe: a mask-modifying instruction ends in this cycle |
| mask_bit | input | 1 | New mask value carried with `mask_wr` (1 = masked) |
| insn_end | input | 1 | Instruction boundary in this cycle |
| bmove_byte | input | 1 | Byte-wide block move in progress |
| bmove_word | input | 1 | Word-wide block move in progress |
| xfer_gap | input | 1 | Break between transfer cycles of a word move |
| req_mask | input | 1 | Maskable interrupt pending |
| req_nmi | input | 1 | Non-maskable interrupt pending |
| int_ack | input | 1 | Acknowledge of the accepted interrupt |
| low_power | input | 1 | Standby or watch mode active |
| irq_pin | input | N_IRQ | External IRQ pins |
| accept | output | 1 | One-cycle acceptance pulse |
| pc_next | output | 1 | Save next-instruction address (word move interrupted) |
| mask_now | output | 1 | Mask bit currently in force |
| irq_level | output | N_IRQ | Conditioned IRQ levels |

## Verification
The properties assume that `bmove_byte` and `bmove_word` are never high together. They also assume that `xfer_gap` only matters while a word move is running. The stimulus builds block moves as exclusive segments of random length and leaves `xfer_gap` undriven in meaning elsewhere. The random phase holds `low_power` at 0 and the pins quiet, so the sticky latch is only touched by the directed pin sequences. `int_ack` is assumed to arrive only as a single strobe, and the bench randomizes it per cycle with no further protocol.

// File: rtl/iag_pkg.sv
package iag_pkg;

    typedef enum logic [1:0] {
        W_OPEN,
        W_COUNT,
        W_AWAIT
    } win_state_e;

    typedef enum logic {
        A_READY,
        A_TAKEN
    } acc_state_e;

endpackage

// File: rtl/iag_irq_cond.sv
module iag_irq_cond #(
    parameter int N_IRQ       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             low_power,
    input  logic             int_ack,
    input  logic [N_IRQ-1:0] irq_pin,
    output logic [N_IRQ-1:0] irq_level
);

    localparam int LAST = SYNC_STAGES - 1;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_pin
        logic [SYNC_STAGES-1:0] chain_q;
        logic                   sticky_q;
        logic                   wake_set;

        assign wake_set = irq_pin[g] & low_power;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                for (int k = LAST; k > 0; k--) begin
                    chain_q[k] <= chain_q[k-1];
                end
                chain_q[0] <= irq_pin[g];
            end
        end

        always_ff @(posedge clk or negedge rst_n or posedge wake_set) begin
            if (!rst_n) begin
                sticky_q <= 1'b0;
            end else if (wake_set) begin
                sticky_q <= 1'b1;
            end else if (int_ack) begin
                sticky_q <= 1'b0;
            end
        end

        assign irq_level[g] = chain_q[LAST] | sticky_q;
    end

endmodule

// File: rtl/iag_mask_pipe.sv
module iag_mask_pipe #(
    parameter int   MASK_LAT = 2,
    parameter logic MASK_RST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_wr,
    input  logic mask_bit,
    output logic mask_now
);

    localparam int STAGES = MASK_LAT - 1;
    localparam int TAIL   = STAGES - 1;

    logic [STAGES-1:0] pend_v_q;
    logic [STAGES-1:0] pend_d_q;
    logic              mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v_q <= '0;
            pend_d_q <= '0;
            mask_q   <= MASK_RST;
        end else begin
            for (int k = TAIL; k > 0; k--) begin
                pend_v_q[k] <= pend_v_q[k-1];
                pend_d_q[k] <= pend_d_q[k-1];
            end
            pend_v_q[0] <= mask_wr;
            pend_d_q[0] <= mask_bit;
            if (pend_v_q[TAIL]) begin
                mask_q <= pend_d_q[TAIL];
            end
        end
    end

    assign mask_now = mask_q;

endmodule

// File: rtl/iag_window_fsm.sv
module iag_window_fsm
    import iag_pkg::*;
#(
    parameter int WIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_wr,
    input  logic insn_end,
    output logic win_open
);

    localparam int              CW       = $clog2(WIN + 1);
    localparam logic [CW-1:0]   CNT_LOAD = CW'(WIN);
    localparam logic [CW-1:0]   CNT_LAST = CW'(1);

    win_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          seen_q, seen_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_OPEN;
            cnt_q   <= '0;
            seen_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            seen_q  <= seen_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        seen_d  = seen_q;
        unique case (state_q)
            W_OPEN: begin
                if (mask_wr) begin
                    state_d = W_COUNT;
                    cnt_d   = CNT_LOAD;
                    seen_d  = 1'b0;
                end
            end
            W_COUNT: begin
                if (mask_wr) begin
                    state_d = W_COUNT;
                    cnt_d   = CNT_LOAD;
                    seen_d  = 1'b0;
                end else begin
                    cnt_d  = cnt_q - CNT_LAST;
                    seen_d = seen_q | insn_end;
                    if (cnt_q == CNT_LAST) begin
                        state_d = (seen_q | insn_end) ? W_OPEN : W_AWAIT;
                    end
                end
            end
            W_AWAIT: begin
                if (mask_wr) begin
                    state_d = W_COUNT;
                    cnt_d   = CNT_LOAD;
                    seen_d  = 1'b0;
                end else if (insn_end) begin
                    state_d = W_OPEN;
                    seen_d  = 1'b1;
                end
            end
            default: begin
                state_d = W_OPEN;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            W_OPEN:  win_open = !mask_wr;
            W_COUNT: win_open = 1'b0;
            W_AWAIT: win_open = !mask_wr && insn_end;
            default: win_open = 1'b0;
        endcase
    end

endmodule

// File: rtl/iag_accept_fsm.sv
module iag_accept_fsm
    import iag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_open,
    input  logic insn_end,
    input  logic bmove_byte,
    input  logic bmove_word,
    input  logic xfer_gap,
    input  logic req_mask,
    input  logic req_nmi,
    input  logic mask_now,
    input  logic int_ack,
    output logic accept,
    output logic pc_next
);

    acc_state_e state_q, state_d;
    logic       at_point;
    logic       eligible;
    logic       fire;

    assign at_point = bmove_word ? xfer_gap : insn_end;
    assign eligible = req_nmi | (req_mask & ~mask_now);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= A_READY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            A_READY: if (fire)    state_d = A_TAKEN;
            A_TAKEN: if (int_ack) state_d = A_READY;
            default:              state_d = A_READY;
        endcase
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            A_READY: fire = win_open && !bmove_byte && at_point && eligible;
            A_TAKEN: fire = 1'b0;
            default: fire = 1'b0;
        endcase
        accept  = fire;
        pc_next = fire && bmove_word;
    end

endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate #(
    parameter int   N_IRQ       = 4,
    parameter int   SYNC_STAGES = 2,
    parameter int   WIN         = 3,
    parameter int   MASK_LAT    = 2,
    parameter logic MASK_RST    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr,
    input  logic             mask_bit,
    input  logic             insn_end,
    input  logic             bmove_byte,
    input  logic             bmove_word,
    input  logic             xfer_gap,
    input  logic             req_mask,
    input  logic             req_nmi,
    input  logic             int_ack,
    input  logic             low_power,
    input  logic [N_IRQ-1:0] irq_pin,
    output logic             accept,
    output logic             pc_next,
    output logic             mask_now,
    output logic [N_IRQ-1:0] irq_level
);

    logic win_open;

    iag_mask_pipe #(
        .MASK_LAT (MASK_LAT),
        .MASK_RST (MASK_RST)
    ) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_wr  (mask_wr),
        .mask_bit (mask_bit),
        .mask_now (mask_now)
    );

    iag_window_fsm #(
        .WIN (WIN)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_wr  (mask_wr),
        .insn_end (insn_end),
        .win_open (win_open)
    );

    iag_accept_fsm u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_open   (win_open),
        .insn_end   (insn_end),
        .bmove_byte (bmove_byte),
        .bmove_word (bmove_word),
        .xfer_gap   (xfer_gap),
        .req_mask   (req_mask),
        .req_nmi    (req_nmi),
        .mask_now   (mask_now),
        .int_ack    (int_ack),
        .accept     (accept),
        .pc_next    (pc_next)
    );

    iag_irq_cond #(
        .N_IRQ       (N_IRQ),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .low_power (low_power),
        .int_ack   (int_ack),
        .irq_pin   (irq_pin),
        .irq_level (irq_level)
    );

endmodule

// File: rtl/iag_checker.sv
module iag_checker #(
    parameter int WIN      = 3,
    parameter int MASK_LAT = 2
) (
    input logic clk,
    input logic rst_n,
    input logic mask_wr,
    input logic mask_bit,
    input logic insn_end,
    input logic bmove_byte,
    input logic bmove_word,
    input logic xfer_gap,
    input logic req_mask,
    input logic req_nmi,
    input logic int_ack,
    input logic accept,
    input logic pc_next,
    input logic mask_now
);

    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] win_cnt_q;
    logic          taken_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt_q <= '0;
            taken_q   <= 1'b0;
        end else begin
            if (mask_wr)              win_cnt_q <= CW'(WIN);
            else if (win_cnt_q != '0) win_cnt_q <= win_cnt_q - CW'(1);
            if (taken_q && int_ack)   taken_q <= 1'b0;
            else if (accept)          taken_q <= 1'b1;
        end
    end

    p_no_accept_on_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |-> !accept);

    p_window_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt_q != '0) |-> !accept);

    if (MASK_LAT == 2) begin : g_lat2
        p_mask_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mask_wr, 2) && !$past(mask_wr, 1)) |-> (mask_now == $past(mask_bit, 2)));

        p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(mask_wr, 1) && !$past(mask_wr, 2)) |-> $stable(mask_now));
    end

    p_byte_move_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bmove_byte |-> !accept);

    p_pc_next_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_next |-> (accept && bmove_word && xfer_gap));

    p_boundary_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !bmove_word) |-> (insn_end && !pc_next));

    p_eligible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_nmi) |-> (req_mask && !mask_now));

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

    p_held_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        taken_q |-> !accept);

endmodule

bind irq_accept_gate iag_checker #(
    .WIN      (WIN),
    .MASK_LAT (MASK_LAT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_wr    (mask_wr),
    .mask_bit   (mask_bit),
    .insn_end   (insn_end),
    .bmove_byte (bmove_byte),
    .bmove_word (bmove_word),
    .xfer_gap   (xfer_gap),
    .req_mask   (req_mask),
    .req_nmi    (req_nmi),
    .int_ack    (int_ack),
    .accept     (accept),
    .pc_next    (pc_next),
    .mask_now   (mask_now)
);

// File: tb/tb_irq_accept_gate.sv
module tb_irq_accept_gate;

    localparam int  N_IRQ    = 4;
    localparam time CLK_PER  = 10;
    localparam int  N_RANDOM = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mask_wr = 0, mask_bit = 0, insn_end = 0;
    logic bmove_byte = 0, bmove_word = 0, xfer_gap = 0;
    logic req_mask = 0, req_nmi = 0, int_ack = 0, low_power = 0;
    logic [N_IRQ-1:0] irq_pin = '0;
    logic accept, pc_next, mask_now;
    logic [N_IRQ-1:0] irq_level;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    int cyc = 0;
    int last_upd = -100;
    bit bound_after = 1;
    bit taken = 0;
    bit p1_v = 0, p1_d = 0;
    bit m_exp = 1;

    always #(CLK_PER/2) clk = ~clk;

    irq_accept_gate #(.N_IRQ(N_IRQ)) dut (
        .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_bit(mask_bit),
        .insn_end(insn_end), .bmove_byte(bmove_byte), .bmove_word(bmove_word),
        .xfer_gap(xfer_gap), .req_mask(req_mask), .req_nmi(req_nmi),
        .int_ack(int_ack), .low_power(low_power), .irq_pin(irq_pin),
        .accept(accept), .pc_next(pc_next), .mask_now(mask_now),
        .irq_level(irq_level)
    );

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic bit model_accept();
        bit win_ok, bound_ok, point, elig;
        win_ok   = !mask_wr && (cyc - last_upd >= 4);
        bound_ok = bound_after || insn_end;
        point    = bmove_word ? xfer_gap : insn_end;
        elig     = req_nmi || (req_mask && !m_exp);
        return !taken && win_ok && bound_ok && !bmove_byte && point && elig;
    endfunction

    function automatic string classify();
        if (mask_wr || (cyc - last_upd < 4)) return "R3";
        if (!(bound_after || insn_end))      return "R4";
        if (bmove_byte)                      return "R6";
        if (bmove_word)                      return "R7";
        if (taken)                           return "R10";
        if (!insn_end)                       return "R8";
        return "R9";
    endfunction

    // Apply current inputs for one cycle; exp_acc < 0 uses the model.
    task automatic tick(string tag, int exp_acc);
        bit ea;
        string t;
        #1;
        ea = model_accept();
        t  = (tag.len() != 0) ? tag : classify();
        chk("R2", int'(mask_now), int'(m_exp));
        if (exp_acc >= 0) chk(t, int'(accept), exp_acc);
        else              chk(t, int'(accept), int'(ea));
        chk(bmove_word ? "R7" : "R8", int'(pc_next), int'(ea && bmove_word));
        if (mask_wr) begin
            last_upd    = cyc;
            bound_after = 0;
        end else if (insn_end) begin
            bound_after = 1;
        end
        if (taken && int_ack) taken = 0;
        else if (ea)          taken = 1;
        if (p1_v) m_exp = p1_d;
        p1_v = mask_wr;
        p1_d = mask_bit;
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        mask_wr = 0; insn_end = 0; bmove_byte = 0; bmove_word = 0;
        xfer_gap = 0; req_mask = 0; req_nmi = 0; int_ack = 0;
    endtask

    task automatic ack_cycle();
        idle_inputs();
        int_ack = 1;
        tick("R10", 0);
        int_ack = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
    end

    initial begin
        int move_left;
        int move_kind;
        void'($urandom(32'h1a2b3c4d));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", int'(accept), 0);
        chk("R1", int'(pc_next), 0);
        chk("R1", int'(mask_now), 1);
        chk("R1", int'(irq_level), 0);
        @(negedge clk);
        cyc = 1;

        // R8: acceptance only at a boundary
        idle_inputs(); req_nmi = 1;
        tick("R8", 0);
        insn_end = 1;
        tick("R8", 1);
        // R10: held until acknowledge, then resumes
        tick("R10", 0);
        int_ack = 1;
        tick("R10", 0);
        int_ack = 0;
        tick("R10", 1);
        ack_cycle();

        // R9: maskable request refused while masked
        idle_inputs(); req_mask = 1; insn_end = 1;
        tick("R9", 0);

        // R2/R3: mask update clears mask, window of three cycles
        idle_inputs(); mask_wr = 1; mask_bit = 0; req_nmi = 1; insn_end = 1;
        tick("R3", 0);
        mask_wr = 0; mask_bit = 0;
        tick("R3", 0);
        tick("R3", 0);
        tick("R3", 0);
        req_nmi = 0; req_mask = 1;
        tick("R9", 1);
        ack_cycle();

        // R4: window expired but no boundary yet
        idle_inputs(); mask_wr = 1; mask_bit = 0;
        tick("R3", 0);
        mask_wr = 0;
        tick("R3", 0);
        tick("R3", 0);
        tick("R3", 0);
        req_nmi = 1; bmove_word = 1; xfer_gap = 1;
        tick("R4", 0);
        bmove_word = 0; xfer_gap = 0; insn_end = 1;
        tick("R4", 1);
        ack_cycle();

        // R5: second update restarts the window
        idle_inputs(); mask_wr = 1; mask_bit = 1;
        tick("R5", 0);
        mask_wr = 0;
        tick("R5", 0);
        mask_wr = 1; mask_bit = 0;
        tick("R5", 0);
        mask_wr = 0; req_nmi = 1; insn_end = 1;
        tick("R5", 0);
        tick("R5", 0);
        tick("R5", 0);
        tick("R5", 1);
        ack_cycle();

        // R6: byte move blocks everything
        idle_inputs(); bmove_byte = 1; req_nmi = 1; insn_end = 1;
        tick("R6", 0);
        xfer_gap = 1;
        tick("R6", 0);
        bmove_byte = 0; xfer_gap = 0;
        tick("R6", 1);
        ack_cycle();

        // R7: word move accepts only at a transfer break
        idle_inputs(); bmove_word = 1; req_nmi = 1; insn_end = 1;
        tick("R7", 0);
        insn_end = 0; xfer_gap = 1;
        #1;
        chk("R7", int'(pc_next), 1);
        tick("R7", 1);
        ack_cycle();

        // Random phase
        move_left = 0;
        move_kind = 0;
        for (int i = 0; i < N_RANDOM; i++) begin
            if (move_left == 0) begin
                move_kind = $urandom_range(0, 3);
                move_left = $urandom_range(2, 9);
            end
            move_left--;
            bmove_byte = (move_kind == 0);
            bmove_word = (move_kind == 1);
            xfer_gap   = bmove_word && ($urandom_range(0, 2) == 0);
            mask_wr    = ($urandom_range(0, 7) == 0);
            mask_bit   = $urandom_range(0, 1);
            insn_end   = ($urandom_range(0, 2) == 0);
            req_nmi    = ($urandom_range(0, 9) == 0);
            req_mask   = $urandom_range(0, 1);
            int_ack    = ($urandom_range(0, 3) == 0);
            tick("", -1);
        end
        idle_inputs();

        // R11: two-edge synchronizer in normal mode
        low_power = 0;
        irq_pin[0] = 1;
        #1; chk("R11", int'(irq_level[0]), 0);
        @(negedge clk); #1; chk("R11", int'(irq_level[0]), 0);
        @(negedge clk); #1; chk("R11", int'(irq_level[0]), 1);
        irq_pin[0] = 0;
        @(negedge clk); #1; chk("R11", int'(irq_level[0]), 1);
        @(negedge clk); #1; chk("R11", int'(irq_level[0]), 0);

        // R12: asynchronous capture in low-power mode
        low_power = 1;
        irq_pin[1] = 1;
        #1; chk("R12", int'(irq_level[1]), 1);
        #2; irq_pin[1] = 0;
        repeat (3) @(negedge clk);
        #1; chk("R12", int'(irq_level[1]), 1);
        chk("R12", int'(irq_level[2]), 0);
        @(negedge clk);
        int_ack = 1;
        @(negedge clk);
        int_ack = 0;
        #1; chk("R12", int'(irq_level[1]), 0);
        low_power = 0;
        @(negedge clk);

        summary();
    end

endmodule